// File: doc/BRIEF.md
# Directional Sequential Tail-Light Sequencer

This block animates a bank of eight indicator LEDs in the manner of a sequential turn signal. The bank is two halves of four. Lamps light one after another, starting at the centre and moving outward, until the half is full. The half then goes dark and the fill starts again, looping with no end. An external speed level chooses how long each step lasts. The count direction chooses which half plays the animation: the right half for counting up, the left half for counting down.

A step-rate divider turns the speed level into an advance pulse, using a per-level period table given as a parameter. A small step controller keeps the position in the fill. A mapper places the fill on the correct half of the bank. Level 0 parks the animation. A change of direction restarts the animation from the empty step on the new half.

Top module: `tail_sweep_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `leds` is all zero. The stored direction is up.
- R2: With `count_down` = 0, only `leds[3:0]` may light. Lit steps 1 to 4 are `leds[3]`, then `leds[3:2]`, then `leds[3:1]`, then `leds[3:0]`.
- R3: With `count_down` = 1, only `leds[7:4]` may light. Lit steps 1 to 4 are `leds[4]`, then `leds[5:4]`, then `leds[6:4]`, then `leds[7:4]`.
- R4: The active half cycles through five steps, with 0, 1, 2, 3 and 4 lamps lit, and returns from 4 lamps to 0 lamps, looping continuously.
- R5: At level L the step advances once every `PERIODS[L]` clock cycles. The first advance after a restart or after leaving level 0 comes `PERIODS[L]` cycles after that event.
- R6: With the default table, a higher level gives more step changes in a fixed window than a lower level.
- R7: Level 0 makes `leds` all zero from the next cycle and returns the step to empty.
- R8: After a change of `count_down`, from the next cycle the half that was active is dark, the new half shows the empty step, and step timing restarts.
- R9: Levels above 5 (6 and 7) behave exactly like level 5.
- R10: A level change between 1 and 5 keeps the current step and the elapsed cycle count. If that count already reaches the new period, the step advances at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| speed_lvl | input | LVL_W (3) | Speed level; 0 parks the animation |
| count_down | input | 1 | 0 selects the right half, 1 selects the left half |
| leds | output | 2*HALF (8) | LED bank; bits [7:4] left half, bits [3:0] right half |

## Verification
A wrong step count shows at the ports as a lamp count that differs from the expected fill within one clock of the error. A wrong divider count shows as a step edge that is early or late, at the next step boundary, which is at most `PERIODS[L]` cycles later. A stale stored direction lights the wrong half, or fails to clear the old half, in the cycle after `count_down` changes. The reference model is compared against `leds` on every cycle, so each of these faults is reported at its first visible cycle.

// File: rtl/tlseq_pkg.sv
package tlseq_pkg;

  typedef enum logic {
    SWEEP_UP   = 1'b0,
    SWEEP_DOWN = 1'b1
  } sweep_dir_e;

  // Levels above the table's top entry run at the top entry's rate.
  function automatic int clamp_level(input int lvl, input int top);
    return (lvl > top) ? top : lvl;
  endfunction

endpackage

// File: rtl/tlseq_rate_div.sv
module tlseq_rate_div #(
  parameter int          NUM_LEVELS = 6,
  parameter int          LVL_W      = 3,
  parameter int unsigned PERIODS [NUM_LEVELS] = '{1, 12, 9, 6, 4, 2}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic [LVL_W-1:0] lvl,
  output logic             adv
);
  import tlseq_pkg::*;

  function automatic int unsigned peak_period();
    int unsigned m = 1;
    for (int i = 0; i < NUM_LEVELS; i++)
      if (PERIODS[i] > m) m = PERIODS[i];
    return m;
  endfunction

  localparam int unsigned PEAK  = peak_period();
  localparam int          CNT_W = (PEAK > 1) ? $clog2(PEAK) : 1;

  logic [CNT_W-1:0] tick_q;
  logic [31:0]      per_sel;
  logic             limit_hit;

  always_comb begin
    per_sel   = PERIODS[clamp_level(int'(lvl), NUM_LEVELS - 1)];
    limit_hit = (32'(tick_q) + 32'd1) >= per_sel;
    adv       = active && !restart && limit_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active || restart || limit_hit) tick_q <= '0;
    else                                           tick_q <= tick_q + 1'b1;
  end

  p_tick_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tick_q) < PEAK);
  p_tick_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> tick_q == '0);
  p_tick_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> tick_q == '0);

endmodule

// File: rtl/tlseq_step_ctl.sv
module tlseq_step_ctl #(
  parameter int HALF = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       active,
  input  logic                       restart,
  input  logic                       adv,
  output logic [$clog2(HALF+1)-1:0]  step
);
  localparam int SW = $clog2(HALF + 1);
  localparam logic [SW-1:0] LAST = SW'(HALF);

  logic [SW-1:0] step_q;
  logic          at_last;

  assign at_last = (step_q == LAST);
  assign step    = step_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !active || restart) step_q <= '0;
    else if (adv)                     step_q <= at_last ? '0 : step_q + 1'b1;
  end

  p_step_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST);
  p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart && adv && !at_last) |=> step_q == $past(step_q) + 1'b1);
  p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart && adv && at_last) |=> step_q == '0);
  p_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart && !adv) |=> $stable(step_q));

endmodule

// File: rtl/tlseq_led_map.sv
module tlseq_led_map #(
  parameter int HALF = 4
) (
  input  logic [$clog2(HALF+1)-1:0] step,
  input  tlseq_pkg::sweep_dir_e     dir,
  output logic [2*HALF-1:0]         leds
);
  import tlseq_pkg::*;

  // Bit k is lit when fewer than step lamps precede it from the centre.
  function automatic logic [HALF-1:0] centre_fill(input int n);
    logic [HALF-1:0] m = '0;
    for (int k = 0; k < HALF; k++) m[k] = (k < n);
    return m;
  endfunction

  function automatic logic [HALF-1:0] flip(input logic [HALF-1:0] v);
    logic [HALF-1:0] r;
    for (int k = 0; k < HALF; k++) r[k] = v[HALF-1-k];
    return r;
  endfunction

  logic [HALF-1:0] fill;

  always_comb begin
    fill = centre_fill(int'(step));
    leds = '0;
    if (dir == SWEEP_DOWN) leds[2*HALF-1:HALF] = fill;
    else                   leds[HALF-1:0]      = flip(fill);
  end

endmodule

// File: rtl/tail_sweep_seq.sv
module tail_sweep_seq #(
  parameter int          NUM_LEVELS = 6,
  parameter int          HALF       = 4,
  parameter int          LVL_W      = 3,
  parameter int unsigned PERIODS [NUM_LEVELS] = '{1, 12, 9, 6, 4, 2}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] speed_lvl,
  input  logic             count_down,
  output logic [2*HALF-1:0] leds
);
  import tlseq_pkg::*;

  localparam int SW = $clog2(HALF + 1);

  sweep_dir_e    dir_q;
  sweep_dir_e    dir_in;
  logic          active;
  logic          restart;
  logic          adv;
  logic [SW-1:0] step;

  assign dir_in  = count_down ? SWEEP_DOWN : SWEEP_UP;
  assign active  = (speed_lvl != '0);
  assign restart = (dir_in != dir_q);

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= SWEEP_UP;
    else        dir_q <= dir_in;
  end

  tlseq_rate_div #(
    .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .PERIODS(PERIODS)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(restart),
    .lvl(speed_lvl), .adv(adv)
  );

  tlseq_step_ctl #(.HALF(HALF)) u_step (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(restart),
    .adv(adv), .step(step)
  );

  tlseq_led_map #(.HALF(HALF)) u_map (
    .step(step), .dir(dir_q), .leds(leds)
  );

  p_dark_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> leds == '0);
  p_switch_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> leds == '0);
  p_right_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == SWEEP_UP) |-> leds[2*HALF-1:HALF] == '0);
  p_left_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == SWEEP_DOWN) |-> leds[HALF-1:0] == '0);
  p_lamp_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(leds) == int'(step));

endmodule

// File: tb/test_tail_sweep_seq.sv
module test_tail_sweep_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] speed_lvl = 3'd0;
  logic       count_down = 1'b0;
  logic [7:0] leds;

  int n_cmp = 0;
  int n_bad = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  int per_tab [6] = '{1, 12, 9, 6, 4, 2};
  int m_tick = 0;
  int m_lit = 0;
  bit m_down = 1'b0;

  always #2 clk = ~clk;

  tail_sweep_seq i_tail_sweep_seq (
    .clk(clk), .rst_n(rst_n), .speed_lvl(speed_lvl),
    .count_down(count_down), .leds(leds)
  );

  function automatic logic [7:0] expect_leds(input int lit, input bit down);
    logic [7:0] v = '0;
    for (int k = 0; k < lit; k++) begin
      if (down) v[4 + k] = 1'b1;
      else      v[3 - k] = 1'b1;
    end
    return v;
  endfunction

  // Behavioural model: count elapsed cycles, light one more lamp per period.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_lit = 0; m_down = 1'b0;
    end else begin
      int lv;
      bit flip;
      lv   = (speed_lvl > 5) ? 5 : int'(speed_lvl);
      flip = (count_down != m_down);
      m_down = count_down;
      if (lv == 0 || flip) begin
        m_tick = 0; m_lit = 0;
      end else begin
        m_tick++;
        if (m_tick >= per_tab[lv]) begin
          m_tick = 0;
          m_lit  = (m_lit + 1) % 5;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      logic [7:0] e;
      e = expect_leds(m_lit, m_down);
      n_cmp++;
      if (leds !== e) begin
        n_bad++;
        $display("FAIL %s: leds=%b expected=%b at %0t", cur_req, leds, e, $time);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_in(input int lv, input bit dn, input string tag);
    @(posedge clk); #1;
    speed_lvl  = 3'(lv);
    count_down = dn;
    cur_req    = tag;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    n_cmp++;
    if (leds !== 8'h00) begin
      n_bad++;
      $display("FAIL R1: leds=%b expected=%b", leds, 8'h00);
    end
    @(posedge clk); #1;
    rst_n  = 1'b1;
    chk_en = 1'b1;
    run(3);

    set_in(3, 1'b0, "R2"); run(80);
    set_in(5, 1'b0, "R4"); run(40);
    set_in(2, 1'b1, "R3"); run(80);
    for (int i = 0; i < 6; i++) begin
      set_in(3, (i % 2) == 0, "R8");
      run(7 + i * 3);
    end
    set_in(0, 1'b1, "R7"); run(10);
    set_in(4, 1'b1, "R7"); run(13);
    set_in(0, 1'b1, "R7"); run(6);
    set_in(7, 1'b0, "R9"); run(30);
    set_in(6, 1'b1, "R9"); run(30);
    set_in(1, 1'b1, "R10"); run(10);
    set_in(5, 1'b1, "R10"); run(12);
    set_in(1, 1'b1, "R10"); run(30);
    set_in(0, 1'b0, "R5"); run(4);
    set_in(2, 1'b0, "R5"); run(60);
    set_in(1, 1'b0, "R5"); run(60);

    // R6: more step changes at level 5 than at level 1 in the same window
    begin
      int chg1 = 0;
      int chg5 = 0;
      logic [7:0] prev;
      set_in(1, 1'b0, "R6");
      @(negedge clk); prev = leds;
      for (int c = 0; c < 120; c++) begin
        @(negedge clk);
        if (leds !== prev) chg1++;
        prev = leds;
      end
      set_in(5, 1'b0, "R6");
      @(negedge clk); prev = leds;
      for (int c = 0; c < 120; c++) begin
        @(negedge clk);
        if (leds !== prev) chg5++;
        prev = leds;
      end
      n_cmp++;
      if (!(chg5 > chg1)) begin
        n_bad++;
        $display("FAIL R6: changes at level5=%0d, expected more than level1=%0d",
                 chg5, chg1);
      end
    end

    chk_en = 1'b0;
    done   = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule